// File: doc/BRIEF.md
# Packed Half-Word Fractional Multiply with Wide Sum

This block multiplies pairs of signed 16-bit half-words taken from two 32-bit operands and returns the sum of both products in a 64-bit word, already moved up by 16 bit positions. Software uses it as one step of a multi-precision multiply. A 2-bit pairing mode chooses which upper and lower halves of the two operands meet in each product. A 1-bit fractional control doubles each product so that Q15 inputs give a Q31 product.

In fractional mode each product is checked on its own for the single pair that would overflow, both inputs being the most negative half-word. That product is clamped to the largest positive 32-bit value, and the other product is not affected. Both products are sign-extended before they are added, so a negative sum fills the upper result bits with ones. There is one register stage with a valid flag. When no new operands arrive, the registered result keeps its last value.

Top module: `qmulw_top`

## Requirements
- R1: `out_valid` is low during reset and on the first clock edge after reset. After that, on every clock edge `out_valid` takes the value that `in_valid` had just before that edge.
- R2: While `in_valid` is low, `result` keeps its last value whatever the operand, mode and fractional inputs do. Reset clears `result` to zero.
- R3: `pair_sel` = 0 adds a.hi*b.lo and a.lo*b.lo. Here hi means bits 31:16 and lo means bits 15:0, and both are signed.
- R4: `pair_sel` = 1 adds a.hi*b.lo and a.lo*b.hi.
- R5: `pair_sel` = 2 adds a.hi*b.hi and a.lo*b.lo.
- R6: `pair_sel` = 3 adds a.lo*b.hi and a.hi*b.hi.
- R7: When `frac_shift` = 1, each product is shifted left by one bit before the addition. When `frac_shift` = 0, no product is shifted.
- R8: When `frac_shift` = 1 and both inputs of a product are 8000 hex, that product alone becomes 7FFFFFFF hex. The other product of the pair is computed normally.
- R9: When `frac_shift` = 0, 8000 hex times 8000 hex is not clamped and gives 40000000 hex.
- R10: The result is the sign-extended 33-bit sum shifted left by 16. So bits 15:0 of `result` are zero when `out_valid` is high.
- R11: Bits 63:48 of a valid `result` all equal the sign of the sum, so a negative sum gives upper bits of all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are present this cycle |
| opnd_a | input | 32 | First packed operand: two signed halves |
| opnd_b | input | 32 | Second packed operand: two signed halves |
| pair_sel | input | 2 | Half-word pairing mode, 0 to 3 |
| frac_shift | input | 1 | 1 doubles each product (fractional alignment) |
| out_valid | output | 1 | `result` holds a new sum |
| result | output | 64 | Sum of the two products, shifted left by 16 |

## Verification
The operands in the small-integer vectors have a different value in every half. Because of this, each of the four pairing modes gives its own sum, and a wrong half selection cannot go unnoticed. Vectors whose upper operand half is negative exercise the sign extension into the top 16 bits. Vectors of all 8000 hex compare the clamped case (frac 1) with the unclamped case (frac 0). Vectors in which only one product meets the 8000 hex pair show that the clamp is applied per product. A random sweep over every mode and both frac values, with 8000 hex injected into the halves, is compared against a model written from the requirements.

// File: rtl/qmulw_pkg.sv
package qmulw_pkg;

    // Pairing of the operand halves that feed the two products
    typedef enum logic [1:0] {
        PAIR_HIA_LOB  = 2'd0,  // a.hi*b.lo + a.lo*b.lo
        PAIR_CROSS    = 2'd1,  // a.hi*b.lo + a.lo*b.hi
        PAIR_STRAIGHT = 2'd2,  // a.hi*b.hi + a.lo*b.lo
        PAIR_LOA_HIB  = 2'd3   // a.lo*b.hi + a.hi*b.hi
    } pair_mode_e;

endpackage

// File: rtl/qmulw_pairsel.sv
module qmulw_pairsel
    import qmulw_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0]     opnd_a,
    input  logic [2*HALF_W-1:0]     opnd_b,
    input  pair_mode_e              mode,
    output logic [1:0][HALF_W-1:0]  x_o,
    output logic [1:0][HALF_W-1:0]  y_o
);
    localparam int WORD_W = 2 * HALF_W;

    logic [HALF_W-1:0] a_hi, a_lo, b_hi, b_lo;

    assign a_hi = opnd_a[WORD_W-1:HALF_W];
    assign a_lo = opnd_a[HALF_W-1:0];
    assign b_hi = opnd_b[WORD_W-1:HALF_W];
    assign b_lo = opnd_b[HALF_W-1:0];

    always_comb begin
        x_o = '0;
        y_o = '0;
        unique case (mode)
            PAIR_HIA_LOB: begin
                x_o[0] = a_hi; y_o[0] = b_lo;
                x_o[1] = a_lo; y_o[1] = b_lo;
            end
            PAIR_CROSS: begin
                x_o[0] = a_hi; y_o[0] = b_lo;
                x_o[1] = a_lo; y_o[1] = b_hi;
            end
            PAIR_STRAIGHT: begin
                x_o[0] = a_hi; y_o[0] = b_hi;
                x_o[1] = a_lo; y_o[1] = b_lo;
            end
            PAIR_LOA_HIB: begin
                x_o[0] = a_lo; y_o[0] = b_hi;
                x_o[1] = a_hi; y_o[1] = b_hi;
            end
            default: begin
                x_o = '0;
                y_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/qmulw_lane.sv
module qmulw_lane #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0]    x_i,
    input  logic [HALF_W-1:0]    y_i,
    input  logic                 frac_i,
    output logic [2*HALF_W-1:0]  prod_o
);
    localparam int                WORD_W  = 2 * HALF_W;
    localparam logic [HALF_W-1:0] HALF_MN = {1'b1, {(HALF_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] WORD_MX = {1'b0, {(WORD_W-1){1'b1}}};

    logic signed [WORD_W-1:0] raw;
    logic        [WORD_W-1:0] aligned;
    logic                     clamp;

    always_comb begin
        raw     = $signed(x_i) * $signed(y_i);
        aligned = frac_i ? (raw <<< 1) : raw;
        clamp   = frac_i && (x_i == HALF_MN) && (y_i == HALF_MN);
        prod_o  = clamp ? WORD_MX : aligned;
    end

endmodule

// File: rtl/qmulw_top.sv
module qmulw_top
    import qmulw_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int RES_W  = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [2*HALF_W-1:0]   opnd_a,
    input  logic [2*HALF_W-1:0]   opnd_b,
    input  logic [1:0]            pair_sel,
    input  logic                  frac_shift,
    output logic                  out_valid,
    output logic [RES_W-1:0]      result
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int EXT_W  = RES_W - WORD_W;
    localparam int SIGN_B = WORD_W + HALF_W;  // sign position of the shifted sum
    localparam int LANES  = 2;

    typedef struct packed {
        logic             valid;
        logic [RES_W-1:0] res;
    } stage_t;

    stage_t st_d, st_q;

    logic [LANES-1:0][HALF_W-1:0] lane_x, lane_y;
    logic [LANES-1:0][WORD_W-1:0] lane_p;
    logic [RES_W-1:0]             sum_ext;

    qmulw_pairsel #(.HALF_W(HALF_W)) u_pairsel (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .mode   (pair_mode_e'(pair_sel)),
        .x_o    (lane_x),
        .y_o    (lane_y)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qmulw_lane #(.HALF_W(HALF_W)) u_lane (
            .x_i    (lane_x[g]),
            .y_i    (lane_y[g]),
            .frac_i (frac_shift),
            .prod_o (lane_p[g])
        );
    end

    always_comb begin
        sum_ext = {{EXT_W{lane_p[0][WORD_W-1]}}, lane_p[0]}
                + {{EXT_W{lane_p[1][WORD_W-1]}}, lane_p[1]};
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res = sum_ext << HALF_W;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.res;

    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
    p_low_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (result[HALF_W-1:0] == '0));
    p_sign_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((&result[RES_W-1:SIGN_B]) || !(|result[RES_W-1:SIGN_B])));

endmodule

// File: tb/qmulw_top_bench.sv
module qmulw_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [1:0]  pair_sel = '0;
    logic        frac_shift = 1'b0;
    logic        out_valid;
    logic [63:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    qmulw_top u_qmulw_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .pair_sel   (pair_sel),
        .frac_shift (frac_shift),
        .out_valid  (out_valid),
        .result     (result)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        frac;
        logic [31:0] a;
        logic [31:0] b;
        logic [63:0] exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 32'h0002_0003, 32'h0000_0005, 64'h0000_0000_0019_0000}, // R3
        '{2'd1, 1'b0, 32'h0002_0003, 32'h0007_0005, 64'h0000_0000_001F_0000}, // R4
        '{2'd2, 1'b0, 32'h0002_0003, 32'h0007_0005, 64'h0000_0000_001D_0000}, // R5
        '{2'd3, 1'b0, 32'h0002_0003, 32'h0007_0005, 64'h0000_0000_0023_0000}, // R6
        '{2'd2, 1'b1, 32'h0002_0003, 32'h0007_0005, 64'h0000_0000_003A_0000}, // R7
        '{2'd2, 1'b0, 32'hFFFF_0001, 32'h0003_0002, 64'hFFFF_FFFF_FFFF_0000}, // R11
        '{2'd2, 1'b1, 32'h8000_8000, 32'h8000_8000, 64'h0000_FFFF_FFFE_0000}, // R8
        '{2'd2, 1'b0, 32'h8000_8000, 32'h8000_8000, 64'h0000_8000_0000_0000}, // R9
        '{2'd2, 1'b1, 32'h8000_8000, 32'h8000_0001, 64'h0000_7FFE_FFFF_0000}, // R8
        '{2'd1, 1'b1, 32'h8000_8000, 32'h0001_8000, 64'h0000_7FFE_FFFF_0000}, // R8
        '{2'd3, 1'b1, 32'h8000_0002, 32'h8000_0000, 64'h0000_7FFD_FFFF_0000}, // R8
        '{2'd2, 1'b0, 32'h8000_8000, 32'h7FFF_7FFF, 64'hFFFF_8001_0000_0000}  // R11
    };

    function automatic longint prod_m(logic [15:0] x, logic [15:0] y, logic f);
        longint p;
        if (f && x == 16'h8000 && y == 16'h8000) return 64'sh7FFF_FFFF;
        p = longint'($signed(x)) * longint'($signed(y));
        return f ? p * 2 : p;
    endfunction

    function automatic logic [63:0] model(logic [1:0] m, logic f, logic [31:0] a, logic [31:0] b);
        longint s;
        case (m)
            2'd0:    s = prod_m(a[31:16], b[15:0], f) + prod_m(a[15:0], b[15:0], f);
            2'd1:    s = prod_m(a[31:16], b[15:0], f) + prod_m(a[15:0], b[31:16], f);
            2'd2:    s = prod_m(a[31:16], b[31:16], f) + prod_m(a[15:0], b[15:0], f);
            default: s = prod_m(a[15:0], b[31:16], f) + prod_m(a[31:16], b[31:16], f);
        endcase
        return 64'(s * 65536);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(logic [1:0] m, logic f, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        pair_sel = m; frac_shift = f; opnd_a = a; opnd_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 64'(out_valid), 64'd0);
        check("R2 reset result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 64'(out_valid), 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            issue(VECS[i].mode, VECS[i].frac, VECS[i].a, VECS[i].b);
            check("R1 valid", 64'(out_valid), 64'd1);
            check($sformatf("R3-R11 vector %0d", i), result, VECS[i].exp);
        end

        // R2: idle inputs change, result must hold and valid must drop
        held = result;
        @(negedge clk);
        pair_sel = 2'd1; frac_shift = 1'b1; opnd_a = 32'h1234_5678; opnd_b = 32'h9ABC_DEF0;
        @(negedge clk);
        check("R1 valid drops", 64'(out_valid), 64'd0);
        check("R2 hold", result, held);

        // back-to-back issue: valid stays high on consecutive cycles (R1)
        @(negedge clk);
        pair_sel = 2'd0; frac_shift = 1'b0; opnd_a = 32'h0001_0001; opnd_b = 32'h0001_0001;
        in_valid = 1'b1;
        @(negedge clk);
        check("R1 b2b first", result, 64'h0000_0000_0002_0000);
        opnd_a = 32'h0003_0001;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 b2b valid", 64'(out_valid), 64'd1);
        check("R3 b2b second", result, 64'h0000_0000_0004_0000);

        // random sweep, all modes and frac values, with 8000 hex injected (R3-R11)
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            logic [1:0]  rm;
            logic        rf;
            ra = $urandom; rb = $urandom;
            rm = 2'(i % 4);
            rf = 1'((i / 4) % 2);
            if ($urandom % 3 == 0) ra[31:16] = 16'h8000;
            if ($urandom % 3 == 0) ra[15:0]  = 16'h8000;
            if ($urandom % 3 == 0) rb[31:16] = 16'h8000;
            if ($urandom % 3 == 0) rb[15:0]  = 16'h8000;
            issue(rm, rf, ra, rb);
            check($sformatf("R3-R8 random mode %0d frac %0d", rm, rf), result, model(rm, rf, ra, rb));
        end

        // reset mid-run clears result (R2)
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 reset clears", result, 64'd0);
        check("R1 reset clears valid", 64'(out_valid), 64'd0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule